// File: doc/BRIEF.md
# I2C Register-Write Target with Auto-Increment

This block is a two-wire serial target that lets a bus master load a bank of fourteen 8-bit control registers. The block runs on the system clock and oversamples both bus lines, so the system clock must run at least sixteen times faster than the bus clock. It finds START and STOP conditions on the bus. It checks the 7-bit target address: five fixed bits, then one bit set by a strap input, then a fixed one. When the address matches, it pulls the data line low to acknowledge.

After the address, a write transfer carries one sub-address byte and then any number of data bytes. Each data byte goes into the register selected by an internal pointer. The pointer then advances, and after the last register it wraps back to register zero. A long burst therefore overwrites the registers written earlier in the same burst. The block never drives the data line high; it only asserts an open-drain pull-down enable. A read request is acknowledged, and the block then leaves the bus alone until the next START. All fourteen registers are always visible on a parallel output.

Top module: `i2c_regwr_target`

## Requirements
- R1: After reset, every register output reads zero and the pull-down enable `sda_oe_o` is low.
- R2: A falling SDA edge while SCL is high starts address decoding from any state, including partway through a transfer (repeated START). A rising SDA edge while SCL is high returns the block to idle.
- R3: The address byte is taken MSB first. Its upper seven bits must be `0,0,1,0,0,strap_i,1` for a match. On a match, `sda_oe_o` is high throughout the ninth SCL high phase. On a mismatch, the block gives no acknowledge for that byte or for any later byte until the next START.
- R4: If the address matches and the lowest bit of the address byte is 1 (read), the block acknowledges. It then keeps `sda_oe_o` low until the next START.
- R5: In a write transfer, the second byte is acknowledged and its low five bits load the register pointer. Its upper three bits are ignored.
- R6: Each byte after the sub-address is taken MSB first, acknowledged, and stored in the register that the pointer selects. Register k appears on `regs_o[8*k+7 : 8*k]`.
- R7: After each data byte, the pointer becomes 0 if it was 13 or more; otherwise it becomes pointer+1.
- R8: A data byte that arrives while the pointer is above 13 is acknowledged, but no register changes.
- R9: `sda_oe_o` changes only while the synchronized SCL is low, except when a STOP releases it. A STOP always leaves `sda_oe_o` low.
- R10: The strap bit takes part in the match: with `strap_i` high, address byte 0x26 matches and 0x22 does not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 1 | Strap pin that supplies the variable address bit |
| sda_oe_o | output | 1 | Open-drain pull-down enable for the data line |
| regs_o | output | 112 | All fourteen registers, register k in bits 8k+7 to 8k |

## Verification
The bench builds the block with its default parameters. These are fourteen registers, a 5-bit pointer and a two-stage synchronizer. With these values, a four-byte burst that starts at sub-address 0x0C crosses the wrap point. A sub-address of 0x1F puts the pointer outside the bank, which exercises the dropped-write path and the wrap from an out-of-range pointer. The bus quarter period is ten system clocks, which leaves enough margin after the synchronizer latency for the bench to sample the acknowledge in the middle of the ninth high phase.

// File: rtl/i2c_regwr_pkg.sv
package i2c_regwr_pkg;

  localparam int BYTE_W = 8;
  localparam int PTR_W  = 5;
  localparam logic [4:0] TGT_FIXED = 5'b00100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_WAIT,
    ST_ACK,
    ST_SKIP
  } tgt_state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_SUB,
    PH_DATA
  } rx_phase_e;

  // Seven received address bits against fixed prefix, strap, fixed one.
  function automatic logic addr_match(input logic [6:0] a, input logic strap);
    return a == {TGT_FIXED, strap, 1'b1};
  endfunction

  // Pointer step with wrap to zero from the last register or beyond.
  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p,
                                                 input logic [PTR_W-1:0] last);
    return (p >= last) ? '0 : p + 1'b1;
  endfunction

  function automatic logic ptr_in_bank(input logic [PTR_W-1:0] p,
                                       input logic [PTR_W-1:0] last);
    return p <= last;
  endfunction

endpackage

// File: rtl/i2c_regwr_sync.sv
module i2c_regwr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic             scl_q;
  logic             sda_q;

  assign raw = {scl_i, sda_i};

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-2:0], raw[l]};
    end
    assign synced[l] = sh[STAGES-1];
  end

  assign scl_s = synced[1];
  assign sda_s = synced[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = !scl_q && scl_s;
  assign scl_fall  = scl_q && !scl_s;
  assign start_evt = scl_q && scl_s && sda_q && !sda_s;
  assign stop_evt  = scl_q && scl_s && !sda_q && sda_s;

endmodule

// File: rtl/i2c_regwr_engine.sv
module i2c_regwr_engine
  import i2c_regwr_pkg::*;
#(
  parameter int NUM_REGS = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda_s,
  input  logic              strap_i,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              ptr_inc,
  output logic [PTR_W-1:0]  ptr_q
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);
  localparam int CNT_W = $clog2(BYTE_W);

  tgt_state_e        st_q;
  rx_phase_e         ph_q;
  logic [CNT_W-1:0]  bitcnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              ack_q;
  logic              rw_q;

  logic [BYTE_W-1:0] rx_byte;
  logic              byte_done;
  logic              ack_now;

  assign rx_byte   = {shreg_q[BYTE_W-2:0], sda_s};
  assign byte_done = (st_q == ST_RX) && scl_rise && (bitcnt_q == CNT_W'(BYTE_W - 1));
  assign ack_now   = (ph_q == PH_ADDR) ? addr_match(rx_byte[7:1], strap_i) : 1'b1;
  assign ptr_inc   = byte_done && (ph_q == PH_DATA);
  assign wr_en     = ptr_inc && ptr_in_bank(ptr_q, LAST);
  assign wr_ptr    = ptr_q;
  assign wr_data   = rx_byte;
  assign sda_oe    = (st_q == ST_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      ph_q     <= PH_ADDR;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      ack_q    <= 1'b0;
      rw_q     <= 1'b0;
      ptr_q    <= '0;
    end else if (start_evt) begin
      st_q     <= ST_RX;
      ph_q     <= PH_ADDR;
      bitcnt_q <= '0;
    end else if (stop_evt) begin
      st_q     <= ST_IDLE;
    end else begin
      case (st_q)
        ST_RX: begin
          if (scl_rise) begin
            shreg_q  <= rx_byte;
            bitcnt_q <= bitcnt_q + 1'b1;
            if (byte_done) begin
              st_q  <= ST_ACK_WAIT;
              ack_q <= ack_now;
              case (ph_q)
                PH_ADDR: rw_q  <= rx_byte[0];
                PH_SUB:  ptr_q <= rx_byte[PTR_W-1:0];
                default: ptr_q <= next_ptr(ptr_q, LAST);
              endcase
            end
          end
        end
        ST_ACK_WAIT: begin
          if (scl_fall) st_q <= ack_q ? ST_ACK : ST_SKIP;
        end
        ST_ACK: begin
          if (scl_fall) begin
            bitcnt_q <= '0;
            case (ph_q)
              PH_ADDR: begin
                if (rw_q) st_q <= ST_SKIP;
                else begin
                  st_q <= ST_RX;
                  ph_q <= PH_SUB;
                end
              end
              PH_SUB: begin
                st_q <= ST_RX;
                ph_q <= PH_DATA;
              end
              default: st_q <= ST_RX;
            endcase
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_regwr_bank.sv
module i2c_regwr_bank
  import i2c_regwr_pkg::*;
#(
  parameter int NUM_REGS = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [PTR_W-1:0]           wr_ptr,
  input  logic [BYTE_W-1:0]          wr_data,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [BYTE_W-1:0] val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                val_q <= '0;
      else if (wr_en && wr_ptr == PTR_W'(i))     val_q <= wr_data;
    end
    assign regs_o[i*BYTE_W +: BYTE_W] = val_q;
  end

endmodule

// File: rtl/i2c_regwr_target.sv
module i2c_regwr_target
  import i2c_regwr_pkg::*;
#(
  parameter int NUM_REGS    = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  input  logic                       strap_i,
  output logic                       sda_oe_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);

  // Named internal events, also observed by the bound checker.
  logic              scl_s;
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_evt;
  logic              stop_evt;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_ptr;
  logic [BYTE_W-1:0] wr_data;
  logic              ptr_inc;
  logic [PTR_W-1:0]  ptr_q;

  i2c_regwr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2c_regwr_engine #(.NUM_REGS(NUM_REGS)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .sda_s     (sda_s),
    .strap_i   (strap_i),
    .sda_oe    (sda_oe_o),
    .wr_en     (wr_en),
    .wr_ptr    (wr_ptr),
    .wr_data   (wr_data),
    .ptr_inc   (ptr_inc),
    .ptr_q     (ptr_q)
  );

  i2c_regwr_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_ptr  (wr_ptr),
    .wr_data (wr_data),
    .regs_o  (regs_o)
  );

endmodule

// File: rtl/i2c_regwr_checker.sv
module i2c_regwr_checker
  import i2c_regwr_pkg::*;
#(
  parameter int NUM_REGS = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             scl_fall,
  input logic             start_evt,
  input logic             stop_evt,
  input logic             sda_oe_o,
  input logic             ptr_inc,
  input logic [PTR_W-1:0] ptr_q
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

  AST_OE_MOVES_WITH_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) && !$past(start_evt) && !$past(stop_evt) |-> !scl_s); // R9

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe_o); // R9

  AST_ACK_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> $past(scl_fall)); // R3

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_inc && (ptr_q >= LAST) |=> ptr_q == '0); // R7

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_inc && (ptr_q < LAST) |=> ptr_q == $past(ptr_q) + 1'b1); // R7

  AST_START_CLEARS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe_o); // R2

endmodule

bind i2c_regwr_target i2c_regwr_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .scl_fall  (scl_fall),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .sda_oe_o  (sda_oe_o),
  .ptr_inc   (ptr_inc),
  .ptr_q     (ptr_q)
);

// File: tb/i2c_regwr_target_bench.sv
module i2c_regwr_target_bench;

  localparam int NREG = 14;
  localparam int Q    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic strap = 1'b0;
  logic sda_oe;
  logic [NREG*8-1:0] regs;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [NREG];
  logic [4:0] mptr;
  logic oe_seen;
  logic mon_on = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_regwr_target u_i2c_regwr_target (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .strap_i  (strap),
    .sda_oe_o (sda_oe),
    .regs_o   (regs)
  );

  always @(negedge clk) if (mon_on && sda_oe) oe_seen = 1'b1;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq();
      scl_m = 1'b1; wq(); wq();
      scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    acked = !sda_line;
    wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic check_bank(input string req);
    for (int k = 0; k < NREG; k++)
      chk(regs[k*8 +: 8] == model[k], req, regs[k*8 +: 8], model[k]);
  endtask

  function automatic logic exp_match(input logic [7:0] a, input logic s);
    return a[7:3] == 5'b00100 && a[2] == s && a[1] == 1'b1;
  endfunction

  task automatic model_write(input logic [7:0] d);
    if (mptr <= 5'd13) model[mptr] = d;
    mptr = (mptr >= 5'd13) ? 5'd0 : mptr + 5'd1;
  endtask

  // addr, sub, first data, byte count
  localparam logic [31:0] VEC [8] = '{
    32'h22_00_11_03,
    32'h22_05_A0_01,
    32'h22_0C_50_04,
    32'h24_03_77_02,
    32'h26_03_77_02,
    32'hA2_03_77_02,
    32'h22_1F_99_02,
    32'h22_E4_33_01
  };

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] a, s, d;
    int n;
    for (int k = 0; k < NREG; k++) model[k] = 8'h00;
    mptr = 5'd0;
    repeat (5) @(negedge clk);
    // R1: reset state
    check_bank("R1");
    chk(sda_oe == 1'b0, "R1", sda_oe, 0);
    rst_n = 1'b1;
    wq();

    // Vector table walk (strap low): R3 R5 R6 R7 R8
    for (int v = 0; v < 8; v++) begin
      {a, s, d} = VEC[v][31:8];
      n = int'(VEC[v][7:0]);
      bus_start();
      send_byte(a, ack);
      chk(ack == exp_match(a, strap), "R3 addr ack", ack, exp_match(a, strap));
      send_byte(s, ack);
      chk(ack == exp_match(a, strap), "R5 sub ack", ack, exp_match(a, strap));
      if (exp_match(a, strap)) mptr = s[4:0];
      for (int j = 0; j < n; j++) begin
        logic [7:0] db;
        db = d + 8'(j);
        send_byte(db, ack);
        chk(ack == exp_match(a, strap), (mptr > 5'd13) ? "R8 ack" : "R6 ack",
            ack, exp_match(a, strap));
        if (exp_match(a, strap)) model_write(db);
      end
      bus_stop();
      chk(sda_oe == 1'b0, "R9 stop release", sda_oe, 0);
      check_bank("R6 R7 R8 bank");
    end

    // R4: read request acknowledged, then no drive
    bus_start();
    send_byte(8'h23, ack);
    chk(ack == 1'b1, "R4 read ack", ack, 1);
    oe_seen = 1'b0; mon_on = 1'b1;
    send_byte(8'hFF, ack);
    send_byte(8'hFF, ack);
    mon_on = 1'b0;
    chk(oe_seen == 1'b0, "R4 released", oe_seen, 0);
    bus_stop();
    check_bank("R4 bank");

    // R3: mismatch ignores bus, drive stays off
    bus_start();
    oe_seen = 1'b0; mon_on = 1'b1;
    send_byte(8'h20, ack);
    send_byte(8'h02, ack);
    send_byte(8'h5A, ack);
    mon_on = 1'b0;
    chk(oe_seen == 1'b0, "R3 mismatch silent", oe_seen, 0);
    bus_stop();
    check_bank("R3 bank");

    // R2: repeated START mid-transfer restarts decode
    bus_start();
    send_byte(8'h22, ack);
    send_byte(8'h07, ack);
    bus_start();
    send_byte(8'h22, ack);
    chk(ack == 1'b1, "R2 restart ack", ack, 1);
    send_byte(8'h08, ack);
    mptr = 5'd8;
    send_byte(8'h5C, ack);
    model_write(8'h5C);
    bus_stop();
    check_bank("R2 bank");

    // R10: strap high changes matched address
    strap = 1'b1;
    wq();
    bus_start();
    send_byte(8'h22, ack);
    chk(ack == 1'b0, "R10 old addr nack", ack, 0);
    bus_stop();
    bus_start();
    send_byte(8'h26, ack);
    chk(ack == 1'b1, "R10 strap addr ack", ack, 1);
    send_byte(8'h0D, ack);
    mptr = 5'd13;
    send_byte(8'hE1, ack); model_write(8'hE1);
    send_byte(8'hE2, ack); model_write(8'hE2);
    bus_stop();
    check_bank("R10 R7 bank");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule